// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits next to a small 8-bit processor core and turns five interrupt sources into one request line with a fixed 16-bit handler address. The five sources are two active-low external pins, a timer 0 overflow flag, a capture/compare array flag, and a shared source. The shared source is the OR of the serial port flag and the timer 1 overflow flag. Software controls the sources through an 8-bit enable register: one global bit and one bit per source.

There is only one service level. When the block is idle and at least one enabled source is pending, it registers the request of the highest-priority source and holds it until the core acknowledges it. After the acknowledge, no request is presented until the core pulses its return-from-interrupt line. Each external pin can be set to falling-edge or low-level detection. An edge event is latched and cleared by the acknowledge of its own vector. Peripheral flags are never cleared here, so a flag that is still set is presented again after the return.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While rst_ni is low, irq_req_o is 0, irq_vec_o is 0x0000 (the reset start address) and en_rdata_o is 0x00.
- R2: Enable register bits: bit 7 is the global enable, bit 4 enables serial/timer-1, bit 3 the capture/compare array, bit 2 external pin 1, bit 1 timer 0, and bit 0 external pin 0. Bits 6 and 5 always read back 0. A write on en_wr_i is visible on en_rdata_o one cycle later.
- R3: While enable bit 7 is 0, irq_req_o never rises, whatever the per-source bits hold.
- R4: When several enabled sources are pending together, they are served in this order, highest first: external 0, timer 0, external 1, capture/compare array, serial/timer-1.
- R5: The vectors are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for the capture/compare array, and 0x0023 for serial/timer-1.
- R6: From an accepted acknowledge until irq_ret_i is pulsed, irq_req_o stays 0, even if a higher-priority source becomes pending.
- R7: A pin with ext_edge_i=1 requests once per falling edge. The latched event is cleared when its vector is acknowledged, so a pin that is held low afterwards raises no new request.
- R8: A pin with ext_edge_i=0 requests while it is low, and it is presented again after a return if it is still low.
- R9: Peripheral flags are not cleared by the block. A timer 0 flag that is still high after a return is presented again.
- R10: The serial flag alone, and the timer 1 flag alone, each raise the request with vector 0x0023.
- R11: Once irq_req_o is 1, it and irq_vec_o hold their values until irq_ack_i, even if the source goes away.
- R12: A peripheral flag that is set while the block is idle and enabled raises irq_req_o at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_ni | input | 2 | External interrupt pins, active low (bit 0 = external 0) |
| ext_edge_i | input | 2 | Per-pin mode: 1 falling edge, 0 low level |
| tmr0_flag_i | input | 1 | Timer 0 overflow flag |
| cca_flag_i | input | 1 | Capture/compare array flag |
| ser_flag_i | input | 1 | Serial port flag |
| tmr1_flag_i | input | 1 | Timer 1 overflow flag |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read-back |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 16 | Handler address of the presented request |
| irq_ack_i | input | 1 | Acknowledge from the core |
| irq_ret_i | input | 1 | Return-from-interrupt pulse |

## Verification
The main function is tested in four ways. First, all five sources are made pending at once by turning on the global enable last. The order of the served vectors then shows the fixed priority and the vector table. Second, a high-priority pin goes low while a lower-priority handler is running; this shows the difference between a non-nesting controller and a nesting one. Third, the same pin is run in edge mode and in level mode while it is held low, which shows a latched event apart from a live level. Fourth, the serial and timer 1 flags are driven one at a time to test the shared source, and a peripheral flag that is never cleared is used to test the automatic re-request.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC   = 5;
  localparam int NUM_PINS  = 2;
  localparam int EN_W      = 8;
  localparam int VEC_W     = 16;
  localparam int GLB_BIT   = 7;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam logic [EN_W-1:0]  EN_MASK   = 8'h9F;
  localparam logic [VEC_W-1:0] RESET_VEC = 16'h0000;

  // Source indices double as priority (0 highest).
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_CCA  = 3;
  localparam int SRC_SER  = 4;

  // Handler slots are 8 bytes apart, starting at 3.
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'(8 * idx + 3);
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_s, prev_q, flag_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= pin_s;
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  // A new edge wins over a clear arriving in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (!edge_mode_i) flag_q <= 1'b0;
    else if (fall)        flag_q <= 1'b1;
    else if (clr_i)       flag_q <= 1'b0;
  end

  assign pend_o = edge_mode_i ? flag_q : ~pin_s;

  // R7
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i && fall |=> flag_q || !edge_mode_i);

  // R7
  edge_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i && clr_i && !fall |=> !flag_q);
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_vec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [EN_W-1:0] wdata_i,
  output logic [EN_W-1:0] en_o
);
  logic [EN_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & EN_MASK;
  end

  assign en_o = en_q;

  // R2
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> en_o == ($past(wdata_i) & EN_MASK));

  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [IDX_W-1:0] win_idx, src_q;
  logic             found, req_q, busy_q, take;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_i[i]) win_idx = IDX_W'(i);
  end

  assign found = |pend_i;
  assign take  = req_q & ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      src_q  <= '0;
      vec_q  <= RESET_VEC;
    end else if (take) begin
      req_q  <= 1'b0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (ret_i) busy_q <= 1'b0;
    end else if (!req_q && found) begin
      req_q <= 1'b1;
      src_q <= win_idx;
      vec_q <= vec_of(int'(win_idx));
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_o[i] = take & (src_q == IDX_W'(i));
  end

  assign req_o = req_q;
  assign vec_o = vec_q;

  // R11
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q && $stable(vec_q));

  // R6
  no_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !ret_i |=> !req_q);

  // R6
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !req_q && busy_q);

  // R4
  top_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) && $past(pend_i[SRC_EXT0]) |-> vec_q == 16'h0003);

  // R12
  prompt_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !busy_q && found |=> req_q);

  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] ext_ni,
  input  logic [NUM_PINS-1:0] ext_edge_i,
  input  logic                tmr0_flag_i,
  input  logic                cca_flag_i,
  input  logic                ser_flag_i,
  input  logic                tmr1_flag_i,
  input  logic                en_wr_i,
  input  logic [EN_W-1:0]     en_wdata_i,
  output logic [EN_W-1:0]     en_rdata_o,
  output logic                irq_req_o,
  output logic [VEC_W-1:0]    irq_vec_o,
  input  logic                irq_ack_i,
  input  logic                irq_ret_i
);
  logic [EN_W-1:0]     en_q;
  logic [NUM_SRC-1:0]  pend, pend_m, clr;
  logic [NUM_PINS-1:0] pin_pend;
  logic                glb_en;

  irq_en_reg u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (en_wr_i),
    .wdata_i (en_wdata_i),
    .en_o    (en_q)
  );

  // Pins occupy the even source slots 0 and 2.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int SI = 2 * p;
    irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_ni[p]),
      .edge_mode_i (ext_edge_i[p]),
      .clr_i       (clr[SI]),
      .pend_o      (pin_pend[p])
    );
  end

  always_comb begin
    pend           = '0;
    pend[SRC_EXT0] = pin_pend[0];
    pend[SRC_TMR0] = tmr0_flag_i;
    pend[SRC_EXT1] = pin_pend[1];
    pend[SRC_CCA]  = cca_flag_i;
    pend[SRC_SER]  = ser_flag_i | tmr1_flag_i;
  end

  assign glb_en = en_q[GLB_BIT];
  assign pend_m = glb_en ? (pend & en_q[NUM_SRC-1:0]) : '0;

  irq_arbiter u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_m),
    .ack_i  (irq_ack_i),
    .ret_i  (irq_ret_i),
    .req_o  (irq_req_o),
    .vec_o  (irq_vec_o),
    .clr_o  (clr)
  );

  assign en_rdata_o = en_q;

  // R3
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> !$rose(irq_req_o));

  // R10
  shared_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_req_o) && $past(pend_m == (NUM_SRC'(1) << SRC_SER)) |-> irq_vec_o == 16'h0023);

  // R2
  unused_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rdata_o[6:5] == 2'b00);
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  ext_n = 2'b11, ext_edge = 2'b00;
  logic        tmr0 = 0, cca = 0, ser = 0, tmr1 = 0;
  logic        en_wr = 0, ack = 0, ret = 0;
  logic [7:0]  en_wd = 0, en_rd;
  logic        req;
  logic [15:0] vec;

  int n_chk = 0, n_fail = 0;
  bit auto_svc = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_ni(ext_n), .ext_edge_i(ext_edge),
    .tmr0_flag_i(tmr0), .cca_flag_i(cca), .ser_flag_i(ser), .tmr1_flag_i(tmr1),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .en_rdata_o(en_rd),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .irq_ret_i(ret)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_en(input logic [7:0] d);
    en_wr = 1; en_wd = d;
    @(negedge clk) en_wr = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk) ack = 0;
  endtask

  task automatic do_ret();
    ret = 1;
    @(negedge clk) ret = 0;
  endtask

  task automatic wait_req(input string tag, input logic [15:0] exp);
    for (int i = 0; i < 30; i++) begin
      if (req) break;
      @(negedge clk);
    end
    check(req && vec == exp, tag, {15'd0, req, vec}, {16'd1, exp});
  endtask

  // Peripheral model: the handler removes its own source.
  task automatic clear_src(input logic [15:0] v);
    case (v)
      16'h0003: ext_n[0] = 1;
      16'h000B: tmr0 = 0;
      16'h0013: ext_n[1] = 1;
      16'h001B: cca = 0;
      16'h0023: begin ser = 0; tmr1 = 0; end
      default: ;
    endcase
  endtask

  // Scoreboard monitor: pops expected vectors as the design presents them.
  task automatic monitor();
    forever begin
      @(negedge clk);
      if (auto_svc && req) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected request", {16'd0, vec}, 32'd0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(vec == e, "R4/R5 service order", {16'd0, vec}, {16'd0, e});
        end
        ack = 1;
        @(negedge clk) ack = 0;
        clear_src(vec);
        repeat (2) @(negedge clk);
        ret = 1;
        @(negedge clk) ret = 0;
      end
    end
  endtask

  task automatic wait_drain(input string tag);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0 && !req, tag, exp_q.size(), 0);
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (100000) @(negedge clk);
        check(0, "watchdog", 0, 1);
        finish_test();
      end
    join_none

    repeat (3) @(negedge clk);
    // R1
    check(!req && vec == 16'h0000 && en_rd == 8'h00, "R1 reset state", {7'd0, req, vec, en_rd}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2
    wr_en(8'hFF);
    check(en_rd == 8'h9F, "R2 unused bits read 0", en_rd, 8'h9F);
    wr_en(8'h60);
    check(en_rd == 8'h00, "R2 unused-only write", en_rd, 8'h00);

    // R3
    wr_en(8'h1F);
    tmr0 = 1;
    repeat (5) @(negedge clk);
    check(!req, "R3 global enable off", req, 0);

    // R4 R5: everything pending, then enable globally.
    ser = 1; cca = 1; ext_n = 2'b00;
    exp_q.push_back(16'h0003); exp_q.push_back(16'h000B); exp_q.push_back(16'h0013);
    exp_q.push_back(16'h001B); exp_q.push_back(16'h0023);
    repeat (4) @(negedge clk);
    auto_svc = 1;
    wr_en(8'h9F);
    wait_drain("R4 all five served");

    // R10
    exp_q.push_back(16'h0023);
    tmr1 = 1;
    wait_drain("R10 timer1 alone");
    exp_q.push_back(16'h0023);
    ser = 1;
    wait_drain("R10 serial alone");
    auto_svc = 0;
    @(negedge clk);

    // R6 / R9
    tmr0 = 1;
    wait_req("R5 timer0 vector", 16'h000B);
    do_ack();
    ext_n[0] = 0;
    repeat (6) @(negedge clk);
    check(!req, "R6 no nesting", req, 0);
    do_ret();
    wait_req("R6 ext0 after return", 16'h0003);
    do_ack();
    ext_n[0] = 1;
    repeat (3) @(negedge clk);
    do_ret();
    wait_req("R9 timer0 flag re-presented", 16'h000B);
    do_ack();
    tmr0 = 0;
    do_ret();

    // R11
    cca = 1;
    wait_req("R5 cca vector", 16'h001B);
    cca = 0;
    repeat (4) @(negedge clk);
    check(req && vec == 16'h001B, "R11 request held", {15'd0, req, vec}, {16'd1, 16'h001B});
    do_ack();
    check(!req, "R11 drops after ack", req, 0);
    do_ret();

    // R7
    ext_edge[1] = 1;
    ext_n[1] = 0;
    wait_req("R7 edge request", 16'h0013);
    do_ack();
    repeat (2) @(negedge clk);
    do_ret();
    repeat (8) @(negedge clk);
    check(!req, "R7 no re-request while held low", req, 0);
    ext_n[1] = 1;
    repeat (4) @(negedge clk);
    ext_n[1] = 0;
    wait_req("R7 second edge", 16'h0013);
    do_ack();
    do_ret();
    ext_n[1] = 1;
    ext_edge[1] = 0;
    repeat (4) @(negedge clk);

    // R8
    ext_n[1] = 0;
    wait_req("R8 level request", 16'h0013);
    do_ack();
    repeat (2) @(negedge clk);
    do_ret();
    wait_req("R8 level re-request", 16'h0013);
    do_ack();
    ext_n[1] = 1;
    repeat (3) @(negedge clk);
    do_ret();
    repeat (4) @(negedge clk);
    check(!req, "R8 idle after release", req, 0);

    // R12
    cca = 1;
    @(negedge clk);
    check(req && vec == 16'h001B, "R12 one-edge latency", {15'd0, req, vec}, {16'd1, 16'h001B});
    do_ack();
    cca = 0;
    do_ret();

    repeat (4) @(negedge clk);
    finish_test();
  end
endmodule